// File: doc/BRIEF.md
# Unrolled Binary-to-Decimal Digit Converter

This block turns an unsigned binary word into packed decimal digits (four bits per digit) with no clock and no iteration. It uses the shift-and-add-3 method, laid out in space instead of time. The bits of the input enter one position per stage. Before each further shift, every decimal digit that could have reached five passes through a small correction cell. That cell adds three when its 4-bit input is 5 or more and drops any carry out of the addition. Nothing else in the path does arithmetic.

The correction cells form a triangle. The units digit is corrected from the third shifted bit onward, and each higher digit starts three stages after the digit below it. With the default 16-bit input the array has 35 cells and produces five digits. A caller drives `bin_i` and reads `bcd_o` in the same cycle, after the settling delay of the array. The correction cell is a module of its own, so it can be instantiated and tested in isolation.

Top module: `bin2bcd_unrolled`

## Requirements
- R1: A correction cell whose 4-bit input is 0 to 4 outputs that input unchanged.
- R2: A correction cell whose 4-bit input is 5 to 15 outputs the input plus 3 modulo 16, so 13, 14 and 15 give 0, 1 and 2.
- R3: `bcd_o` holds the decimal digits four bits each. Bits 3:0 are the units, and each higher nibble is the next power of ten, so bits 19:16 hold the ten-thousands.
- R4: Every 4-bit digit at the output of the converter lies in 0 to 9. Inside the array, every digit that feeds a correction cell also lies in 0 to 9.
- R5: An input of 0 yields all-zero digits.
- R6: An input of 65535 yields the digits 6, 5, 5, 3, 5 (0x65535 on `bcd_o`).
- R7: For every 16-bit input value v, the sum of digit j times 10 to the power j equals v.
- R8: A correction cell never outputs 5, 6 or 7.
- R9: The converter is purely combinational. A change on `bin_i` appears on `bcd_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | 16 | Unsigned binary value to convert |
| bcd_o | output | 20 | Packed decimal digits, ten-thousands in the top nibble |

## Verification
Immediate assertions run on every evaluation of the array. They confirm that each cell sees a digit no larger than 9 and never emits 5, 6 or 7. They also confirm that no set bit is lost off the top of the digit register during a shift, and that every output digit is a legal decimal digit. Only the bench can show that the digits are the correct decimal value. It does this with a sweep over all 65536 inputs, together with the named extremes and an exhaustive run of the standalone cell across all sixteen codes.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  // Number of decimal digits needed for the largest unsigned value of width w.
  function automatic int num_digits(input int w);
    longint unsigned v;
    int n;
    v = (longint'(1) <<< w) - 1;
    n = 0;
    while (v != 0) begin
      v = v / 10;
      n++;
    end
    if (n == 0) n = 1;
    return n;
  endfunction

  // A correction cell sits on digit dig after step shifted bits
  // once the digit could plausibly reach five: step >= 3*(dig+1).
  function automatic bit cell_here(input int step, input int dig);
    return step >= 3 * (dig + 1);
  endfunction

endpackage

// File: rtl/bcd_adj_cell.sv
module bcd_adj_cell (
  input  logic [3:0] nib_i,
  output logic [3:0] nib_o
);

  always_comb begin
    nib_o = (nib_i >= 4'd5) ? nib_i + 4'd3 : nib_i;
  end

  // R8: codes 5..7 are unreachable on the output of a cell
  always_comb begin
    p_out_gap_r8: assert (!(nib_o == 4'd5 || nib_o == 4'd6 || nib_o == 4'd7))
      else $error("cell emitted %0d from %0d", nib_o, nib_i);
  end

endmodule

// File: rtl/bcd_dabble_stage.sv
module bcd_dabble_stage #(
  parameter int NDIG = 5,
  parameter int STEP = 3
) (
  input  logic [4*NDIG-1:0] shf_i,
  output logic [4*NDIG-1:0] cor_o
);

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    if (bcd_pkg::cell_here(STEP, j)) begin : g_cell
      bcd_adj_cell u_cell (
        .nib_i (shf_i[4*j +: 4]),
        .nib_o (cor_o[4*j +: 4])
      );

      // R4: a digit entering a cell is a legal decimal digit
      always_comb begin
        p_cell_in_dec_r4: assert (shf_i[4*j +: 4] <= 4'd9)
          else $error("step %0d digit %0d sees %0d", STEP, j, shf_i[4*j +: 4]);
      end

      // R4: hence a corrected digit never exceeds 12
      always_comb begin
        p_cell_out_max_r4: assert (cor_o[4*j +: 4] <= 4'd12)
          else $error("step %0d digit %0d gives %0d", STEP, j, cor_o[4*j +: 4]);
      end
    end else begin : g_pass
      assign cor_o[4*j +: 4] = shf_i[4*j +: 4];
    end
  end

endmodule

// File: rtl/bin2bcd_unrolled.sv
module bin2bcd_unrolled #(
  parameter int WIDTH = 16,
  parameter int NDIG  = bcd_pkg::num_digits(WIDTH)
) (
  input  logic [WIDTH-1:0]  bin_i,
  output logic [4*NDIG-1:0] bcd_o
);

  localparam int DW = 4 * NDIG;

  // chain[m]: digit register after m input bits were shifted in and corrected
  logic [DW-1:0] chain [WIDTH+1];
  logic [DW-1:0] shifted [WIDTH+1];

  assign chain[0]   = '0;
  assign shifted[0] = '0;

  for (genvar m = 1; m <= WIDTH; m++) begin : g_step
    assign shifted[m] = {chain[m-1][DW-2:0], bin_i[WIDTH-m]};

    if (m < WIDTH) begin : g_fix
      bcd_dabble_stage #(
        .NDIG (NDIG),
        .STEP (m)
      ) u_stage (
        .shf_i (shifted[m]),
        .cor_o (chain[m])
      );
    end else begin : g_last
      assign chain[m] = shifted[m];
    end

    // R4: the shift never pushes a set bit off the top digit
    always_comb begin
      p_no_spill_r4: assert (chain[m-1][DW-1] == 1'b0)
        else $error("bit lost at step %0d", m);
    end
  end

  assign bcd_o = chain[WIDTH];

  for (genvar j = 0; j < NDIG; j++) begin : g_chk
    // R4: each output digit is decimal
    always_comb begin
      p_out_dec_r4: assert (bcd_o[4*j +: 4] <= 4'd9)
        else $error("output digit %0d is %0d", j, bcd_o[4*j +: 4]);
    end
  end

  // R5: zero maps to zero and only zero maps to zero
  always_comb begin
    p_zero_iff_r5: assert ((bin_i == '0) == (bcd_o == '0))
      else $error("zero mismatch bin=%0d bcd=%h", bin_i, bcd_o);
  end

endmodule

// File: tb/bin2bcd_unrolled_test.sv
`timescale 1ns/1ps
module bin2bcd_unrolled_test;

  logic        clk = 1'b0;
  logic [15:0] bin_i;
  logic [19:0] bcd_o;
  logic [3:0]  c_in;
  logic [3:0]  c_out;
  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  bin2bcd_unrolled uut (.bin_i(bin_i), .bcd_o(bcd_o));
  bcd_adj_cell cell_uut (.nib_i(c_in), .nib_o(c_out));

  function automatic logic [19:0] ref_bcd(input int v);
    logic [19:0] r;
    int t;
    t = v;
    r = '0;
    for (int j = 0; j < 5; j++) begin
      r[4*j +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bin_i = '0;
    c_in  = '0;
    @(negedge clk);
    // R5: reset/idle value
    check(bcd_o == 20'h0, "R5", int'(bcd_o), 0);

    // R1 R2 R8: standalone cell over all codes
    for (int x = 0; x < 16; x++) begin
      @(posedge clk);
      c_in = 4'(x);
      @(negedge clk);
      if (x < 5) check(c_out == 4'(x), "R1", int'(c_out), x);
      else       check(c_out == 4'((x + 3) % 16), "R2", int'(c_out), (x + 3) % 16);
      check(!(c_out inside {4'd5, 4'd6, 4'd7}), "R8", int'(c_out), 0);
    end

    // R6 and R3: named points
    @(posedge clk);
    bin_i = 16'hFFFF;
    @(negedge clk);
    check(bcd_o == 20'h65535, "R6", int'(bcd_o), 'h65535);
    bin_i = 16'd12345;
    #1;
    check(bcd_o == 20'h12345, "R3", int'(bcd_o), 'h12345);
    // R9: change between edges, no clock needed
    bin_i = 16'd9;
    #1;
    check(bcd_o == 20'h00009, "R9", int'(bcd_o), 'h9);
    bin_i = 16'd10000;
    #1;
    check(bcd_o == 20'h10000, "R9", int'(bcd_o), 'h10000);

    // R7 R4: exhaustive sweep
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk);
      bin_i = 16'(v);
      @(negedge clk);
      begin
        logic [19:0] e;
        bit legal;
        e = ref_bcd(v);
        check(bcd_o == e, "R7", int'(bcd_o), int'(e));
        legal = 1'b1;
        for (int j = 0; j < 5; j++) if (bcd_o[4*j +: 4] > 4'd9) legal = 1'b0;
        check(legal, "R4", int'(bcd_o), int'(e));
        if (v == 0) check(bcd_o == 20'h0, "R5", int'(bcd_o), 0);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule